// File: doc/BRIEF.md
# Fading LED Channel PWM Engine

This block produces the drive enables for the three LED channels of one pixel. A load strobe gives each channel a two-bit mode: dark, fully lit, ramp up or ramp down. A ramp moves a 7-bit brightness level one step on each rising edge of an external sync clock, or two steps when the speed bit that was captured with the load is set. A free-running PWM counter is compared against each channel's level. The resulting active-low enable suits an open-drain output stage.

A ramp stops at its end point and stays there until another load arrives. Each load restarts the ramp from its starting value. If no sync edges arrive, the duty cycle stays constant. The serial shifting that delivers the modes and the analog output stage are outside this block.

Each channel runs its own state machine, with these states:

| State | Meaning |
|---|---|
| `CH_OFF` | Dark |
| `CH_FULL` | Forced fully on |
| `CH_RISE` | Ramping up |
| `CH_PEAK` | Held at maximum after a ramp up |
| `CH_FALL` | Ramping down |
| `CH_FLOOR` | Held dark after a ramp down |

The transitions are:

- **Load:** from any state, a load goes to the state picked by the mode, as follows. 00 goes to `CH_OFF`. 01 goes to `CH_FULL`. 10 goes to `CH_RISE`. 11 goes to `CH_FALL`.
- **Top reached:** `CH_RISE` goes to `CH_PEAK` when a step reaches level 127.
- **Bottom reached:** `CH_FALL` goes to `CH_FLOOR` when a step reaches level 0.
- **No change:** every other state stays where it is until the next load.

Top module: `fade_pwm_engine`

## Requirements
- R1: After reset every bit of `drive_n` is 1 (all channels dark).
- R2: A load with mode 00 keeps the channel's `drive_n` at 1 on every cycle. A load with mode 01 keeps it at 0 on every cycle, starting two clocks after the load.
- R3: A load with mode 10 sets the level to 0. Afterwards, each rising sync edge with the speed bit at 0 raises the level by one.
- R4: The speed bit is captured on load. When the captured value is 1, each rising sync edge moves a ramping level by two instead of one.
- R5: A ramp up stops at level 127 and holds there, whatever further sync edges arrive, until the next load.
- R6: A load with mode 11 sets the level to 127. Each rising sync edge lowers it, and it stops at 0 and holds there until the next load.
- R7: A load in the middle of a ramp restarts the ramp from its starting level.
- R8: Only rising edges of `sync_in` change a level. Sync edges reach the level three clocks after the input rises, because of two synchronizer flops and one edge-detect flop. With `sync_in` static, the duty cycle does not change.
- R9: The PWM period is 128 × `DIV` clocks. A ramping or holding channel drives `drive_n` low while the PWM count is below its level, so it is low for exactly level × `DIV` clocks out of every period. Channel i takes its mode from `mode_in[2i+1:2i]`.
- R10: When a load and a sync step fall in the same clock, the load wins and the step is discarded.
- R11: Changes on `mode_in` or `speed_in` without a load have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | One-cycle strobe that applies `mode_in` and `speed_in` |
| mode_in | input | 2*NCH | Two mode bits per channel |
| speed_in | input | 1 | 1 selects double step size |
| sync_in | input | 1 | Asynchronous sync/speed clock |
| drive_n | output | NCH | Active-low channel enables |

## Verification
A wrong level or state shows up directly as a wrong duty cycle on `drive_n`. A lost or extra step changes the number of low cycles in the next PWM period. A wrong state transition shows up within one PWM period as saturation in the wrong place, or as a failure to hold. The bench runs a behavioural model clock by clock and compares every channel enable on every cycle. It also counts low cycles over full PWM periods, so a divergence is seen on the first cycle where the PWM count crosses the erroneous level.

// File: rtl/fade_pkg.sv
package fade_pkg;

    typedef enum logic [1:0] {
        MODE_DARK = 2'b00,
        MODE_LIT  = 2'b01,
        MODE_RISE = 2'b10,
        MODE_FALL = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        CH_OFF   = 3'd0,
        CH_FULL  = 3'd1,
        CH_RISE  = 3'd2,
        CH_PEAK  = 3'd3,
        CH_FALL  = 3'd4,
        CH_FLOOR = 3'd5
    } ch_state_e;

endpackage

// File: rtl/sync_step.sv
module sync_step (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic step
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= sync_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign step = sync_q & ~prev_q;

    // R8: a rising edge gives a single-cycle step pulse
    a_r8_step_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

endmodule

// File: rtl/pwm_base.sv
module pwm_base #(
    parameter int LVL_W = 7,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [LVL_W-1:0] pwm_cnt
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            pwm_cnt <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) pwm_cnt <= pwm_cnt + 1'b1;
        end
    end

    // R9: the count only moves on a prescaler tick
    a_r9_count_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pwm_cnt));

endmodule

// File: rtl/fade_channel.sv
module fade_channel
    import fade_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  mode_e            mode,
    input  logic             fast,
    input  logic             step,
    input  logic [LVL_W-1:0] pwm_cnt,
    output logic             drive_n
);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
    localparam logic [LVL_W-1:0] ONE     = LVL_W'(1);
    localparam logic [LVL_W-1:0] TWO     = LVL_W'(2);

    ch_state_e        state, nxt_state;
    logic [LVL_W-1:0] level, nxt_level;
    logic [LVL_W-1:0] inc;

    assign inc = fast ? TWO : ONE;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_OFF;
            level <= '0;
        end else begin
            state <= nxt_state;
            level <= nxt_level;
        end
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_level = level;
        if (load) begin
            unique case (mode)
                MODE_DARK: begin nxt_state = CH_OFF;  nxt_level = '0;      end
                MODE_LIT:  begin nxt_state = CH_FULL; nxt_level = LVL_MAX; end
                MODE_RISE: begin nxt_state = CH_RISE; nxt_level = '0;      end
                MODE_FALL: begin nxt_state = CH_FALL; nxt_level = LVL_MAX; end
            endcase
        end else if (step) begin
            unique case (state)
                CH_RISE: begin
                    if (level >= LVL_MAX - inc) begin
                        nxt_state = CH_PEAK;
                        nxt_level = LVL_MAX;
                    end else begin
                        nxt_level = level + inc;
                    end
                end
                CH_FALL: begin
                    if (level <= inc) begin
                        nxt_state = CH_FLOOR;
                        nxt_level = '0;
                    end else begin
                        nxt_level = level - inc;
                    end
                end
                default: ;
            endcase
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drive_n <= 1'b1;
        else        drive_n <= !((state == CH_FULL) || (pwm_cnt < level));
    end

    // R3: a rising ramp never goes down without a load
    a_r3_rise_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RISE && !load) |=> level >= $past(level));

    // R6: a falling ramp never goes up without a load
    a_r6_fall_no_increase: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_FALL && !load) |=> level <= $past(level));

    // R8: without a step or load the level holds
    a_r8_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(level));

    // R2: the fully lit state drives the enable low
    a_r2_full_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_FULL) |=> !drive_n);

    // R4: a fast step adds two away from the top
    a_r4_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && fast && state == CH_RISE && level < LVL_MAX - TWO)
        |=> level == $past(level) + TWO);

    // R5: the peak holds until the next load
    a_r5_peak_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_PEAK && !load) |=> (state == CH_PEAK && level == LVL_MAX));

    // R7 / R10: a ramp-up load restarts at zero even with a step present
    a_r7_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode == MODE_RISE) |=> (level == '0 && state == CH_RISE));

endmodule

// File: rtl/fade_pwm_engine.sv
module fade_pwm_engine
    import fade_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int LVL_W = 7,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2*NCH-1:0] mode_in,
    input  logic             speed_in,
    input  logic             sync_in,
    output logic [NCH-1:0]   drive_n
);
    logic             step;
    logic             fast_q;
    logic [LVL_W-1:0] pwm_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    fast_q <= 1'b0;
        else if (load) fast_q <= speed_in;
    end

    // R11: the captured speed changes only on a load
    a_r11_speed_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(fast_q));

    sync_step u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .step    (step)
    );

    pwm_base #(.LVL_W(LVL_W), .DIV(DIV)) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_cnt (pwm_cnt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        fade_channel #(.LVL_W(LVL_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .mode    (mode_e'(mode_in[2*i +: 2])),
            .fast    (fast_q),
            .step    (step),
            .pwm_cnt (pwm_cnt),
            .drive_n (drive_n[i])
        );
    end

endmodule

// File: tb/tb_fade_pwm_engine.sv
module tb_fade_pwm_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 3;
    localparam int DIV  = 4;
    localparam int PER  = 128 * DIV;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load = 1'b0;
    logic [5:0]     mode_in = '0;
    logic           speed_in = 1'b0;
    logic           sync_in = 1'b0;
    logic [NCH-1:0] drive_n;

    int checks = 0;
    int errors = 0;
    string req_tag = "R9";

    fade_pwm_engine #(.NCH(NCH), .LVL_W(7), .DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .mode_in(mode_in),
        .speed_in(speed_in), .sync_in(sync_in), .drive_n(drive_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model; modes: 0 dark, 1 lit, 2 up, 3 down
    int m_s1, m_s2, m_s3, m_pre, m_cnt, m_spd;
    int m_mode [NCH];
    int m_lvl  [NCH];
    int m_drv  [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0; m_cnt = 0; m_spd = 0;
            for (int c = 0; c < NCH; c++) begin
                m_mode[c] = 0; m_lvl[c] = 0; m_drv[c] = 1;
            end
        end else begin
            bit stp;
            stp = (m_s2 == 1) && (m_s3 == 0);
            for (int c = 0; c < NCH; c++)
                m_drv[c] = ((m_mode[c] == 1) || (m_cnt < m_lvl[c])) ? 0 : 1;
            if (m_pre == DIV - 1) begin
                m_pre = 0;
                m_cnt = (m_cnt + 1) % 128;
            end else begin
                m_pre = m_pre + 1;
            end
            if (load) begin
                m_spd = speed_in;
                for (int c = 0; c < NCH; c++) begin
                    m_mode[c] = mode_in[2*c +: 2];
                    m_lvl[c]  = (m_mode[c] == 0 || m_mode[c] == 2) ? 0 : 127;
                end
            end else if (stp) begin
                for (int c = 0; c < NCH; c++) begin
                    int inc;
                    inc = m_spd ? 2 : 1;
                    if (m_mode[c] == 2) m_lvl[c] = (m_lvl[c] + inc > 127) ? 127 : m_lvl[c] + inc;
                    if (m_mode[c] == 3) m_lvl[c] = (m_lvl[c] - inc < 0) ? 0 : m_lvl[c] - inc;
                end
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                checks++;
                if (drive_n[c] !== m_drv[c][0]) begin
                    errors++;
                    $display("FAIL %s cycle ch%0d drive_n actual %b expected %0d",
                             req_tag, c, drive_n[c], m_drv[c]);
                end
            end
        end
    end

    task automatic do_load(input logic [5:0] modes, input logic spd);
        @(negedge clk);
        mode_in = modes; speed_in = spd; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sync_in = 1'b1;
            repeat (4) @(negedge clk);
            sync_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_duty(input int ch, input int lvl, input string tag);
        int lows = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (drive_n[ch] === 1'b0) lows++;
        end
        checks++;
        if (lows != lvl * DIV) begin
            errors++;
            $display("FAIL %s duty ch%0d low cycles actual %0d expected %0d",
                     tag, ch, lows, lvl * DIV);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (drive_n !== 3'b111) begin
            errors++;
            $display("FAIL R1 reset drive_n actual %b expected 111", drive_n);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2, R9: ch0 lit (01), ch1 dark (00), ch2 up (10)
        req_tag = "R2";
        do_load(6'b10_00_01, 1'b0);
        check_duty(0, 128, "R2");
        check_duty(1, 0, "R2");
        check_duty(2, 0, "R3");

        // R3: ten rising edges at normal speed
        req_tag = "R3";
        pulses(10);
        check_duty(2, 10, "R3");

        // R11: inputs change without load
        req_tag = "R11";
        @(negedge clk); mode_in = 6'b11_11_00; speed_in = 1'b1;
        check_duty(2, 10, "R11");
        check_duty(0, 128, "R11");

        // R8: sync held high, then low, no extra steps
        req_tag = "R8";
        @(negedge clk); sync_in = 1'b1;
        repeat (6) @(negedge clk);
        check_duty(2, 11, "R8");
        @(negedge clk); sync_in = 1'b0;
        repeat (6) @(negedge clk);
        check_duty(2, 11, "R8");

        // R4, R6: ch2 down at double speed
        req_tag = "R4";
        do_load(6'b11_00_00, 1'b1);
        check_duty(2, 127, "R6");
        pulses(5);
        check_duty(2, 117, "R4");
        req_tag = "R6";
        pulses(70);
        check_duty(2, 0, "R6");

        // R5, R6: ch0 up, ch1 down, ch2 up at normal speed, run past ends
        req_tag = "R5";
        do_load(6'b10_11_10, 1'b0);
        check_duty(1, 127, "R6");
        pulses(140);
        check_duty(0, 127, "R5");
        check_duty(1, 0, "R6");
        check_duty(2, 127, "R5");

        // R7: reload in mid-ramp restarts
        req_tag = "R7";
        do_load(6'b10_11_10, 1'b0);
        pulses(20);
        check_duty(0, 20, "R7");
        do_load(6'b10_11_10, 1'b0);
        check_duty(0, 0, "R7");
        check_duty(1, 127, "R7");

        // R10: load coincides with the step pulse
        req_tag = "R10";
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mode_in = 6'b10_11_10; speed_in = 1'b0; load = 1'b1;
        @(negedge clk); load = 1'b0;
        repeat (4) @(negedge clk); sync_in = 1'b0;
        repeat (4) @(negedge clk);
        check_duty(0, 0, "R10");
        check_duty(1, 127, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule